// File: doc/BRIEF.md
# Capture/Compare/PWM Unit

This peripheral owns one 16-bit data register and puts it to one of three uses, chosen by a control register. In capture mode, a selected edge on an external input copies the current value of a shared 16-bit free-running timer (timer A) into the register. In compare mode, the register is matched against timer A. A match raises an event and can set or clear an output pin, or it can ask for timer A to be reset to zero. In PWM mode, the register becomes a duty-cycle store that is driven from a separate 8-bit period timer (timer B). That timer supplies a one-cycle wrap strobe at its period match.

Software reaches the low byte, the high byte and the control register through a byte-wide port. Several units can share both timers. They then differ only in the build-time choice of whether a special-event match also emits a trigger pulse. Units in PWM mode on a shared timer B all reload their duty at the same wrap.

Top module: `ccp_unit`

## Requirements
- R1: Address 0 selects the low data byte, address 1 the high data byte and address 2 the control register. The control register keeps bits [2:0] as the mode and reads its other bits as 0. A write is visible on `rdata_o` in the next cycle. After reset the data and mode are 0, and `pin_o`, `irq_o`, `tmr_a_clr_o` and `trig_o` are low.
- R2: Mode 0 (off) drives `pin_o` low from the cycle after the control write. The pin stays low while the mode remains off.
- R3: Modes 1 (rising) and 2 (falling) are the capture modes. A selected edge on `cap_i` passes a two-stage synchronizer. Timer A is then stored into the 16-bit register at the third rising clock edge after `cap_i` changes. `irq_o` is high for the one cycle that follows that edge.
- R4: In a capture mode, an edge of the other polarity leaves the register unchanged and does not raise `irq_o`.
- R5: Modes 3 to 6 are the compare modes. In the first cycle in which timer A equals the register, a match occurs and `irq_o` pulses in the next cycle. Mode 3 starts with the pin low and drives it high on a match. Mode 4 starts with the pin high and drives it low on a match. Mode 5 leaves the pin at its current value, both on entry and on a match.
- R6: Mode 6 is the special-event mode. `tmr_a_clr_o` is high, combinationally, for exactly the first match cycle, so timer A is zero in the next cycle. The pin is left unchanged and `irq_o` pulses.
- R7: With parameter `SEV_START`=1, `trig_o` equals `tmr_a_clr_o`. With `SEV_START`=0, `trig_o` stays low while `tmr_a_clr_o` still pulses.
- R8: Mode 7 is PWM. In the cycle after a wrap strobe, `pin_o` goes high if the buffered duty d is non-zero. It goes low when timer B reaches d, so the pin is high exactly for timer B values 0..d-1.
- R9: In PWM mode, a write to the low byte takes effect only at the next wrap, when the low byte is copied into the high byte. The high byte reads back as the active duty, and writes to it are ignored.
- R10: A duty of 0 keeps the pin low for the whole period. A duty above the period keeps the pin high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 low, 1 high, 2 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| tmr_a_i | input | 16 | Shared 16-bit timer A value |
| tmr_b_i | input | 8 | Shared 8-bit timer B value |
| tmr_b_wrap_i | input | 1 | High in the cycle timer B is at its period value |
| cap_i | input | 1 | Asynchronous capture input |
| pin_o | output | 1 | Compare/PWM output pin |
| irq_o | output | 1 | One-cycle event strobe for capture and compare |
| tmr_a_clr_o | output | 1 | Request to clear timer A at the next edge |
| trig_o | output | 1 | Special-event trigger pulse |

## Verification
Each result is due in a different cycle. Register writes and the compare pin take effect after one clock edge. `tmr_a_clr_o` and `trig_o` are combinational in the match cycle itself. A capture lands at the third edge after the input changes and takes the timer value from the cycle before that edge. The bench drives inputs and samples at falling clock edges. It checks the clear request in the cycle where its own model of timer A equals the target, and it checks the pin and strobe one falling edge later. For PWM, it follows its own model of timer B and records the pin at each timer value across a whole period. It then compares the pattern bit by bit against the expected duty.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_CAP_RISE = 3'd1,
    MODE_CAP_FALL = 3'd2,
    MODE_CMP_SET  = 3'd3,
    MODE_CMP_CLR  = 3'd4,
    MODE_CMP_FLAG = 3'd5,
    MODE_CMP_SEV  = 3'd6,
    MODE_PWM      = 3'd7
  } ccp_mode_e;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  function automatic logic is_cmp(ccp_mode_e m);
    return (m == MODE_CMP_SET) || (m == MODE_CMP_CLR) ||
           (m == MODE_CMP_FLAG) || (m == MODE_CMP_SEV);
  endfunction

endpackage

// File: rtl/ccp_edge_sync.sv
module ccp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~hist_q;
  assign fall_o = ~sync_q[STAGES-1] & hist_q;

endmodule

// File: rtl/ccp_compare.sv
module ccp_compare #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] tmr_i,
  input  logic [W-1:0] ref_i,
  output logic         hit_o
);

  logic match, match_q;

  assign match = en_i && (tmr_i == ref_i);

  // hold-off: one hit per run of equal cycles; cleared when disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= match;
  end

  assign hit_o = match & ~match_q;

endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] tmr_i,
  input  logic         wrap_i,
  input  logic [W-1:0] duty_next_i,
  input  logic [W-1:0] duty_cur_i,
  output logic         pin_o,
  output logic         load_o
);

  logic       pin_q;
  logic [W:0] tmr_nx;
  logic       end_hit;

  // compare against next timer value so the pin falls as timer reaches duty
  assign tmr_nx  = {1'b0, tmr_i} + {{W{1'b0}}, 1'b1};
  assign end_hit = (tmr_nx == {1'b0, duty_cur_i});
  assign load_o  = en_i && wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pin_q <= 1'b0;
    else if (!en_i)   pin_q <= 1'b0;
    else if (wrap_i)  pin_q <= (duty_next_i != '0);
    else if (end_hit) pin_q <= 1'b0;
  end

  assign pin_o = pin_q;

  a_r8_wrap_sets_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap_i && duty_next_i != '0) |=> pin_o);

  a_r10_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && duty_cur_i == '0) |-> !pin_o);

endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit SEV_START   = 1'b1,
  localparam int DATA_W     = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] tmr_a_i,
  input  logic [BYTE_W-1:0] tmr_b_i,
  input  logic              tmr_b_wrap_i,
  input  logic              cap_i,
  output logic              pin_o,
  output logic              irq_o,
  output logic              tmr_a_clr_o,
  output logic              trig_o
);

  ccp_mode_e         mode_q, mode_wr;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              cmp_pin_q, irq_q;
  logic              cap_rise, cap_fall, capture;
  logic              cmp_en, cmp_hit, sev_hit;
  logic              pwm_en, pwm_pin, pwm_load;
  logic              wr_lo, wr_hi, wr_ctrl;

  assign wr_lo   = we_i && (addr_i == ADDR_LO);
  assign wr_hi   = we_i && (addr_i == ADDR_HI);
  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign mode_wr = ccp_mode_e'(wdata_i[2:0]);

  ccp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cap_i),
    .rise_o(cap_rise),
    .fall_o(cap_fall)
  );

  assign capture = ((mode_q == MODE_CAP_RISE) && cap_rise) ||
                   ((mode_q == MODE_CAP_FALL) && cap_fall);

  assign cmp_en = is_cmp(mode_q);

  ccp_compare #(.W(DATA_W)) u_cmp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cmp_en),
    .tmr_i (tmr_a_i),
    .ref_i ({hi_q, lo_q}),
    .hit_o (cmp_hit)
  );

  assign pwm_en = (mode_q == MODE_PWM);

  ccp_pwm #(.W(BYTE_W)) u_pwm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (pwm_en),
    .tmr_i      (tmr_b_i),
    .wrap_i     (tmr_b_wrap_i),
    .duty_next_i(lo_q),
    .duty_cur_i (hi_q),
    .pin_o      (pwm_pin),
    .load_o     (pwm_load)
  );

  // data register: capture beats software, period load owns high byte in PWM
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (capture)    lo_q <= tmr_a_i[BYTE_W-1:0];
      else if (wr_lo) lo_q <= wdata_i;

      if (capture)                hi_q <= tmr_a_i[DATA_W-1:BYTE_W];
      else if (pwm_load)          hi_q <= lo_q;
      else if (wr_hi && !pwm_en)  hi_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_OFF;
    else if (wr_ctrl) mode_q <= mode_wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_pin_q <= 1'b0;
    end else if (wr_ctrl) begin
      case (mode_wr)
        MODE_CMP_CLR:                cmp_pin_q <= 1'b1;
        MODE_CMP_FLAG, MODE_CMP_SEV: cmp_pin_q <= cmp_pin_q;
        default:                     cmp_pin_q <= 1'b0;
      endcase
    end else if (!cmp_en) begin
      cmp_pin_q <= 1'b0;
    end else if (cmp_hit) begin
      if (mode_q == MODE_CMP_SET)      cmp_pin_q <= 1'b1;
      else if (mode_q == MODE_CMP_CLR) cmp_pin_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= capture || cmp_hit;
  end

  assign sev_hit     = cmp_hit && (mode_q == MODE_CMP_SEV);
  assign tmr_a_clr_o = sev_hit;

  generate
    if (SEV_START) begin : g_trig
      assign trig_o = sev_hit;
    end else begin : g_no_trig
      assign trig_o = 1'b0;
    end
  endgenerate

  assign pin_o = pwm_en ? pwm_pin : cmp_pin_q;
  assign irq_o = irq_q;

  always_comb begin
    case (addr_i)
      ADDR_LO:   rdata_o = lo_q;
      ADDR_HI:   rdata_o = hi_q;
      ADDR_CTRL: rdata_o = {{(BYTE_W-3){1'b0}}, mode_q};
      default:   rdata_o = '0;
    endcase
  end

  a_r2_off_pin_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OFF) |-> !pin_o);

  a_r3_capture_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> (irq_o && ({hi_q, lo_q} == $past(tmr_a_i))));

  a_r5_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_CMP_SET && cmp_hit && !wr_ctrl) |=> pin_o);

  a_r6_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_a_clr_o |=> !tmr_a_clr_o);

  a_r7_trig_with_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> tmr_a_clr_o);

  a_r9_hi_held_pwm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en && !tmr_b_wrap_i) |=> (hi_q == $past(hi_q)));

endmodule

// File: tb/tb_ccp_unit.sv
module tb_ccp_unit;

  localparam int P = 9;  // timer B period value: counts 0..P

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata, rdata_b;
  logic [15:0] ta = 16'd0;
  logic [7:0]  tbc = 8'd0;
  logic        wrap;
  logic        cap = 1'b0;
  logic        pin, irq, clr, trig;
  logic        pin_b, irq_b, clr_b, trig_b;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign wrap = (tbc == P[7:0]);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ta <= 16'd0;
    else if (clr) ta <= 16'd0;
    else          ta <= ta + 16'd1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tbc <= 8'd0;
    else if (wrap) tbc <= 8'd0;
    else           tbc <= tbc + 8'd1;
  end

  ccp_unit #(.SEV_START(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tmr_a_i(ta), .tmr_b_i(tbc), .tmr_b_wrap_i(wrap),
    .cap_i(cap), .pin_o(pin), .irq_o(irq), .tmr_a_clr_o(clr), .trig_o(trig)
  );

  ccp_unit #(.SEV_START(1'b0)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_b), .tmr_a_i(ta), .tmr_b_i(tbc), .tmr_b_wrap_i(wrap),
    .cap_i(cap), .pin_o(pin_b), .irq_o(irq_b), .tmr_a_clr_o(clr_b), .trig_o(trig_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] l, h;
    rd(2'd0, l);
    rd(2'd1, h);
    v = {h, l};
  endtask

  task automatic wait_ta(input logic [15:0] tgt);
    for (int i = 0; i < 4000; i++) begin
      if (ta == tgt) break;
      @(negedge clk);
    end
  endtask

  // records pin over one full timer B period (bit i = timer value i)
  task automatic pwm_period(output logic [15:0] pat);
    pat = '0;
    for (int i = 0; i < 100; i++) begin
      if (tbc == P[7:0]) break;
      @(negedge clk);
    end
    for (int i = 0; i <= P; i++) begin
      @(negedge clk);
      pat[i] = pin;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 reset lo", v, 0);
    rd(2'd1, v); chk("R1 reset hi", v, 0);
    rd(2'd2, v); chk("R1 reset ctrl", v, 0);
    chk("R1 reset outputs", {pin, irq, clr, trig}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'hF8);
    rd(2'd0, v); chk("R1 lo readback", v, 8'hA5);
    rd(2'd1, v); chk("R1 hi readback", v, 8'h3C);
    rd(2'd2, v); chk("R1 ctrl upper bits zero", v, 8'h00);
    wr(2'd2, 8'hFA);
    rd(2'd2, v); chk("R1 ctrl mode field", v, 8'h02);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_capture();
    logic [15:0] exp, v;
    wr(2'd2, 8'd1);
    repeat (4) @(negedge clk);
    cap = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exp = ta;
    chk("R3 no strobe before capture", irq, 0);
    @(negedge clk);
    rd16(v);
    chk("R3 rising capture value", v, exp);
    chk("R3 rising capture strobe", irq, 1);
    @(negedge clk);
    chk("R3 strobe one cycle", irq, 0);
    // R4: falling edge ignored in rising mode
    cap = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R4 falling ignored strobe", irq, 0);
    end
    rd16(v);
    chk("R4 data kept", v, exp);
    // falling mode
    wr(2'd2, 8'd2);
    cap = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R4 rising ignored in falling mode", irq, 0);
    end
    cap = 1'b0;
    @(negedge clk);
    @(negedge clk);
    exp = ta;
    @(negedge clk);
    rd16(v);
    chk("R3 falling capture value", v, exp);
    chk("R3 falling capture strobe", irq, 1);
    wr(2'd2, 8'd0);
  endtask

  task automatic load_target(output logic [15:0] tgt);
    tgt = ta + 16'd40;
    wr(2'd0, tgt[7:0]);
    wr(2'd1, tgt[15:8]);
  endtask

  task automatic t_compare();
    logic [15:0] tgt;
    // mode 3: pin set on match
    wr(2'd2, 8'd0);
    load_target(tgt);
    wr(2'd2, 8'd3);
    chk("R5 set mode starts low", pin, 0);
    wait_ta(tgt);
    chk("R5 set mode pin before match", pin, 0);
    chk("R6 no clear outside special mode", clr, 0);
    @(negedge clk);
    chk("R5 set mode pin after match", pin, 1);
    chk("R5 set mode strobe", irq, 1);
    @(negedge clk);
    chk("R5 strobe one cycle", irq, 0);
    // mode 5: pin untouched
    load_target(tgt);
    wr(2'd2, 8'd5);
    chk("R5 flag mode keeps pin on entry", pin, 1);
    wait_ta(tgt);
    @(negedge clk);
    chk("R5 flag mode strobe", irq, 1);
    chk("R5 flag mode keeps pin on match", pin, 1);
    // mode 4: pin cleared on match
    wr(2'd2, 8'd0);
    load_target(tgt);
    wr(2'd2, 8'd4);
    chk("R5 clear mode starts high", pin, 1);
    wait_ta(tgt);
    @(negedge clk);
    chk("R5 clear mode pin after match", pin, 0);
    chk("R5 clear mode strobe", irq, 1);
    // mode 6: special event
    wr(2'd2, 8'd0);
    load_target(tgt);
    wr(2'd2, 8'd6);
    wait_ta(tgt);
    chk("R6 clear request at match", clr, 1);
    chk("R7 trigger with start enabled", trig, 1);
    chk("R7 other unit clear request", clr_b, 1);
    chk("R7 other unit no trigger", trig_b, 0);
    @(negedge clk);
    chk("R6 timer A cleared", ta, 0);
    chk("R6 clear request single cycle", clr, 0);
    chk("R6 special strobe", irq, 1);
    chk("R6 pin unchanged", pin, 0);
    wr(2'd2, 8'd0);
  endtask

  task automatic t_pwm();
    logic [15:0] pat;
    logic [7:0]  v;
    wr(2'd2, 8'd0);
    wr(2'd0, 8'd4);
    wr(2'd2, 8'd7);
    pwm_period(pat);
    chk("R8 duty 4 pattern", pat, 16'h000F);
    // R9: mid-period writes
    pat = '0;
    for (int i = 0; i <= P; i++) begin
      @(negedge clk);
      pat[i] = pin;
      if (i == 2) begin we = 1'b1; addr = 2'd0; wdata = 8'd7; end
      if (i == 3) we = 1'b0;
      if (i == 5) begin we = 1'b1; addr = 2'd1; wdata = 8'h55; end
      if (i == 6) we = 1'b0;
      if (i == 8) begin
        rd(2'd1, v);
        chk("R9 high byte write ignored", v, 8'd4);
      end
    end
    chk("R9 current period keeps old duty", pat, 16'h000F);
    pwm_period(pat);
    chk("R9 new duty after wrap", pat, 16'h007F);
    rd(2'd1, v);
    chk("R9 high byte shows active duty", v, 8'd7);
    wr(2'd0, 8'd0);
    pwm_period(pat);
    chk("R10 zero duty stays low", pat, 16'h0000);
    wr(2'd0, 8'd200);
    pwm_period(pat);
    chk("R10 duty above period stays high", pat, 16'h03FF);
    chk("R2 pin high before off", pin, 1);
    wr(2'd2, 8'd0);
    chk("R2 off forces low", pin, 0);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk("R2 stays low while off", pin, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_capture();
    t_compare();
    t_pwm();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule